// File: doc/BRIEF.md
# Serial Nibble Register Access Master

This block runs one register access at a time on a clock chip over a three-wire serial link. The link has a serial clock, a data output with its own output enable, and a data input. Together the output, the enable and the input make up a single bidirectional data line outside the block. The chip-enable line is handled outside the block.

The host presents a 4-bit address, a 4-bit write value and a read/not-write flag, and pulses a request. The block shifts a 16-bit-time frame out most significant bit first. For a read, it releases the data line after the address. It skips four input bit times and then collects four data bits. At the end it pulses done. Read data stays on its output until the next read finishes.

A divider parameter `DIV` sets the number of system clock cycles in each half of a serial bit time.

Top module: `nib3w_master`

## Requirements
- R1: After reset, busy, done, sclk and sdo_oe are low and rdata is 0.
- R2: Every frame opens with a 4-bit header, sent first to last: 1, the read/not-write flag (1 = read, 0 = write), 1, 0.
- R3: Bit times 5 to 8 of a frame carry the address, bit 3 first and bit 0 last.
- R4: A write continues with a second header of 1, 0, 0, 1. It then sends wdata, bit 3 first. sdo_oe is high for all 16 bit times.
- R5: A read holds sdo_oe high for the first 8 bit times and low for the last 8. It ignores the sdi values of bit times 9 to 12. rdata is built from bit times 13 to 16, with the first of these becoming bit 3.
- R6: Each access gives exactly 16 sclk pulses. Each bit time spans 2*DIV clock cycles: sclk is low for DIV cycles and then high for DIV cycles. sdo is stable while sclk is high, sdi is sampled as sclk rises, and sclk is low when idle.
- R7: Busy rises in the cycle after an accepted request and falls with done. A request made while busy is ignored: it produces no extra frame.
- R8: Done is a single-cycle pulse. rdata changes only when done ends a read, and a write leaves rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start an access (taken only when idle) |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Register address |
| wdata | input | 4 | Value to write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse at the end of an access |
| rdata | output | 4 | Last value read |
| sclk | output | 1 | Serial clock, low when idle |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data line |
| sdi | input | 1 | Serial data in |

## Verification
The hardest case to reach from the ports is a read in which the discarded bit times carry misleading values. If the sampling window is off by one bit, the result then differs. The bench's serial slave model therefore drives the inverse of the register value during the four skipped bit times and the true value during the last four, changing sdi only as sclk falls. A second case is a request that arrives in the middle of a read. The bench raises one mid-frame, then counts sclk pulses and done pulses to confirm that no second frame follows.

// File: rtl/nib3w_master.sv
module nib3w_master #(
  parameter int DIV = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       rnw,
  input  logic [3:0] addr,
  input  logic [3:0] wdata,
  output logic       busy,
  output logic       done,
  output logic [3:0] rdata,
  output logic       sclk,
  output logic       sdo,
  output logic       sdo_oe,
  input  logic       sdi
);

  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DLAST = DW'(DIV - 1);

  logic [15:0]   frame;
  logic [3:0]    bitcnt;
  logic [DW-1:0] divcnt;
  logic          phase;
  logic          rnw_q;
  logic [3:0]    rsh;

  wire tick    = (divcnt == DLAST);
  wire in_bit  = rnw_q && (bitcnt >= 4'd12);

  assign sclk   = busy & phase;
  assign sdo    = frame[15];
  assign sdo_oe = busy & (~rnw_q | ~bitcnt[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      rdata  <= 4'h0;
      frame  <= 16'h0;
      bitcnt <= 4'h0;
      divcnt <= '0;
      phase  <= 1'b0;
      rnw_q  <= 1'b0;
      rsh    <= 4'h0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy   <= 1'b1;
          rnw_q  <= rnw;
          bitcnt <= 4'h0;
          divcnt <= '0;
          phase  <= 1'b0;
          frame  <= rnw ? {4'b1110, addr, 8'h00}
                        : {4'b1010, addr, 4'b1001, wdata};
        end
      end else if (tick) begin
        divcnt <= '0;
        if (!phase) begin
          phase <= 1'b1;
          if (in_bit) rsh <= {rsh[2:0], sdi};
        end else begin
          phase <= 1'b0;
          frame <= {frame[14:0], 1'b0};
          if (bitcnt == 4'd15) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (rnw_q) rdata <= rsh;
          end else begin
            bitcnt <= bitcnt + 4'd1;
          end
        end
      end else begin
        divcnt <= divcnt + DW'(1);
      end
    end
  end

endmodule

module nib3w_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [3:0] rdata,
  input logic       sclk,
  input logic       sdo,
  input logic       sdo_oe
);

  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R6
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));

  // R1
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdo_oe);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

bind nib3w_master nib3w_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rdata(rdata),
  .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/nib3w_master_tb.sv
module nib3w_master_tb_top;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, rnw = 1'b0, sdi = 1'b0;
  logic [3:0] addr = 4'h0, wdata = 4'h0;
  logic busy, done, sclk, sdo, sdo_oe;
  logic [3:0] rdata;

  int checks = 0, failures = 0;
  int cyc = 0;

  logic [15:0] pat = 16'h0;
  int sidx = 0;
  logic [15:0] rec = 16'h0, oerec = 16'h0;
  int rises = 0;
  int rise_cyc[2];

  logic [15:0] q_frame[$];
  logic [15:0] q_mask[$];
  logic [4:0]  q_rd[$];

  logic [3:0] last_rd = 4'h0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nib3w_master #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .rnw(rnw), .addr(addr),
    .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
    .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge sclk) begin
    rec   = {rec[14:0], sdo};
    oerec = {oerec[14:0], sdo_oe};
    if (rises < 2) rise_cyc[rises] = cyc;
    rises++;
  end

  always @(negedge sclk) begin
    if (sidx < 15) begin
      sidx++;
      sdi = pat[15-sidx];
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        logic [15:0] ef, em;
        logic [4:0] er;
        ef = q_frame.pop_front();
        em = q_mask.pop_front();
        er = q_rd.pop_front();
        // R2 R3 R4: header, address and write tail on sdo
        chk((rec & em) == (ef & em), "R2/R3/R4 frame", rec & em, ef & em);
        // R4 R5: output enable per bit time
        chk(oerec == em, "R4/R5 oe", oerec, em);
        // R6: sixteen pulses
        chk(rises == 16, "R6 pulses", rises, 16);
        // R6: bit time length
        chk(rise_cyc[1] - rise_cyc[0] == 2*DIV, "R6 bit time",
            rise_cyc[1] - rise_cyc[0], 2*DIV);
        if (er[4]) begin
          // R5: data from bit times 13..16
          chk(rdata == er[3:0], "R5 rdata", rdata, er[3:0]);
        end else begin
          // R8: write keeps rdata
          chk(rdata == last_rd, "R8 rdata kept", rdata, last_rd);
        end
        @(negedge clk);
        // R8: one-cycle done
        chk(done == 1'b0, "R8 done width", done, 0);
        chk(sclk == 1'b0, "R6 sclk idle", sclk, 0);
      end
    end
  end

  task automatic access(input bit r, input logic [3:0] a, input logic [3:0] w,
                        input logic [3:0] v, input bit intrude);
    logic [15:0] ef;
    ef = r ? {4'b1110, a, 8'h00} : {4'b1010, a, 4'b1001, w};
    q_frame.push_back(ef);
    q_mask.push_back(r ? 16'hFF00 : 16'hFFFF);
    q_rd.push_back({r, v});
    pat = {8'h00, ~v, v};
    sidx = 0;
    sdi = pat[15];
    rec = 16'h0;
    oerec = 16'h0;
    rises = 0;
    @(negedge clk);
    req = 1'b1; rnw = r; addr = a; wdata = w;
    @(negedge clk);
    req = 1'b0;
    // R7: busy follows accepted request
    chk(busy == 1'b1, "R7 busy rise", busy, 1);
    if (intrude) begin
      repeat (30) @(negedge clk);
      req = 1'b1; rnw = 1'b0; addr = 4'hF; wdata = 4'hF;
      @(negedge clk);
      req = 1'b0;
    end
    while (!done) @(negedge clk);
    if (r) last_rd = v;
    repeat (3) @(negedge clk);
    if (intrude) begin
      repeat (8) @(negedge clk);
      // R7: mid-frame request produced nothing
      chk(busy == 1'b0, "R7 ignored busy", busy, 0);
      chk(rises == 16, "R7 ignored pulses", rises, 16);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(sdo_oe == 1'b0, "R1 oe", sdo_oe, 0);
    chk(rdata == 4'h0, "R1 rdata", rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    access(1'b0, 4'hD, 4'h6, 4'h0, 1'b0);
    access(1'b1, 4'h5, 4'h0, 4'hA, 1'b0);
    access(1'b0, 4'h0, 4'hF, 4'h0, 1'b0);
    access(1'b1, 4'hF, 4'h0, 4'h3, 1'b1);
    access(1'b1, 4'h8, 4'h0, 4'h0, 1'b0);
    access(1'b1, 4'h1, 4'h0, 4'hF, 1'b0);
    access(1'b0, 4'h7, 4'h8, 4'h0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule